// File: doc/BRIEF.md
# Sprite Attribute Block Copy Engine

This block copies a fixed-length block of bytes from a selectable 256-byte page of system memory into a fixed object-attribute window. Software starts a copy with one write to an 8-bit page register. The written byte becomes the high address byte of the source, and the low byte starts at zero. The engine then waits a fixed startup delay. After that it runs in four-cycle slots, and each slot moves one byte: a read from the source, a capture of the returned byte, a write to the destination, and an idle cycle.

The destination window begins at 0xFE00. Byte i is read from the page base plus i and written to 0xFE00 plus i. The copy is 160 bytes long (index 0x00 to 0x9F). When the last slot ends, the engine pulses a done flag, clears its page register and goes idle. A new page write during a copy restarts the sequence from the startup delay, using the new page and index zero. Bus arbitration, CPU stalling and the memories are outside this block.

Top module: `oam_copy_top`

## Requirements
- R1: After reset, busy, done, busRdEn and busWrEn are 0 and regRdData reads 0x00.
- R2: A cycle with regWrEn high stores regWrData. From the next cycle, regRdData returns that byte and busy is 1, and busy stays 1 until the copy ends.
- R3: Call the first cycle after the page write cycle k=0. In cycles k=0 to k=3, neither busRdEn nor busWrEn is asserted.
- R4: Byte i (0 to 159) is read in cycle k=4+4i, with busRdEn=1 and busAddr = {page, 8'h00} + i.
- R5: Read data arrives on busRdData one cycle after the read. Byte i is written in cycle k=6+4i, with busWrEn=1, busAddr = 0xFE00 + i, and busWrData equal to the byte that read returned.
- R6: Cycles k=5+4i and k=7+4i have no bus access, busRdEn and busWrEn are never high together, and exactly 160 reads and 160 writes happen per copy.
- R7: In cycle k=644, done is 1 for exactly that cycle, busy is 0 and regRdData reads 0x00. No bus access follows until the next page write.
- R8: A page write during a copy (in any state or slot phase) restarts the sequence. The new write cycle is the new k=-1, R3 to R7 apply to the new page, and no further access goes to the old page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Page register write strobe |
| regWrData | input | 8 | Page byte to write |
| regRdData | output | 8 | Current page register value |
| busAddr | output | 16 | Master bus address |
| busRdEn | output | 1 | Master read request |
| busRdData | input | 8 | Read data, valid one cycle after busRdEn |
| busWrEn | output | 1 | Master write request |
| busWrData | output | 8 | Write data |
| busy | output | 1 | High while a copy is pending or running |
| done | output | 1 | One-cycle pulse when a copy completes |

## Verification
The assertions take for granted that busRdData returns the addressed byte exactly one cycle after a read. They also assume that the environment does nothing to the bus beyond answering reads. The bench's memory model is a registered function of the address, so this latency always holds and every expected byte can be computed from the address. Page writes happen only at chosen points, including every slot phase and the startup window. This covers restarts wherever they can occur, while each copy still obeys the fixed slot timing.

// File: rtl/oam_copy_pkg.sv
package oam_copy_pkg;

  typedef enum logic [1:0] {
    COPY_IDLE  = 2'd0,
    COPY_WAIT  = 2'd1,
    COPY_MOVE  = 2'd2
  } copyState_t;

  typedef struct packed {
    logic loadPage;
    logic rdSlot;
    logic capture;
    logic wrSlot;
    logic advance;
    logic finish;
  } copyStrobes_t;

endpackage

// File: rtl/oam_copy_ctrl.sv
module oam_copy_ctrl
  import oam_copy_pkg::*;
#(
  parameter int STARTUP_CYCLES = 4,
  parameter int SLOT_CYCLES    = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         regWrEn,
  input  logic         lastIdx,
  output copyStrobes_t st,
  output logic         busy,
  output logic         done
);

  localparam int MAX_CNT = (STARTUP_CYCLES > SLOT_CYCLES) ? STARTUP_CYCLES : SLOT_CYCLES;
  localparam int TICK_W  = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;
  localparam logic [TICK_W-1:0] WAIT_LAST = TICK_W'(STARTUP_CYCLES - 1);
  localparam logic [TICK_W-1:0] SLOT_LAST = TICK_W'(SLOT_CYCLES - 1);

  copyState_t        state;
  logic [TICK_W-1:0] tick;
  logic              inMove;

  assign inMove = (state == COPY_MOVE);

  always_comb begin
    st          = '0;
    st.loadPage = regWrEn;
    st.rdSlot   = inMove && (tick == TICK_W'(0));
    st.capture  = inMove && (tick == TICK_W'(1));
    st.wrSlot   = inMove && (tick == TICK_W'(2));
    st.advance  = inMove && (tick == SLOT_LAST);
    st.finish   = st.advance && lastIdx;
  end

  assign busy = (state != COPY_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= COPY_IDLE;
      tick  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (regWrEn) begin
        state <= COPY_WAIT;
        tick  <= '0;
      end else begin
        unique case (state)
          COPY_WAIT: begin
            if (tick == WAIT_LAST) begin
              state <= COPY_MOVE;
              tick  <= '0;
            end else begin
              tick <= tick + TICK_W'(1);
            end
          end
          COPY_MOVE: begin
            if (tick == SLOT_LAST) begin
              tick <= '0;
              if (lastIdx) begin
                state <= COPY_IDLE;
                done  <= 1'b1;
              end
            end else begin
              tick <= tick + TICK_W'(1);
            end
          end
          default: tick <= '0;
        endcase
      end
    end
  end

  assert_no_rdwr_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(st.rdSlot && st.wrSlot));

  assert_wr_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st.wrSlot |-> $past(st.rdSlot, 2));

  assert_startup_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st.loadPage |=> !(st.rdSlot || st.wrSlot));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/oam_copy_dpath.sv
module oam_copy_dpath
  import oam_copy_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          BLOCK_LEN = 160,
  parameter logic [15:0] DEST_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  copyStrobes_t      st,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              lastIdx
);

  localparam int OFS_W = ADDR_W - DATA_W;
  localparam int IDX_W = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLOCK_LEN - 1);

  logic [DATA_W-1:0] pageReg;
  logic [DATA_W-1:0] holdReg;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] srcAddr;
  logic [ADDR_W-1:0] dstAddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pageReg <= '0;
      idx     <= '0;
      holdReg <= '0;
    end else begin
      if (st.loadPage) begin
        pageReg <= regWrData;
        idx     <= '0;
      end else if (st.finish) begin
        pageReg <= '0;
        idx     <= '0;
      end else if (st.advance) begin
        idx <= idx + IDX_W'(1);
      end
      if (st.capture) holdReg <= busRdData;
    end
  end

  assign srcAddr   = {pageReg, {OFS_W{1'b0}}} + ADDR_W'(idx);
  assign dstAddr   = ADDR_W'(DEST_BASE) + ADDR_W'(idx);
  assign lastIdx   = (idx == IDX_LAST);
  assign regRdData = pageReg;
  assign busWrData = holdReg;

  always_comb begin
    if (st.rdSlot)      busAddr = srcAddr;
    else if (st.wrSlot) busAddr = dstAddr;
    else                busAddr = '0;
  end

  assert_src_in_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st.rdSlot |-> (busAddr[OFS_W-1:0] < OFS_W'(BLOCK_LEN)));

  assert_dst_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st.wrSlot |-> ((busAddr >= ADDR_W'(DEST_BASE)) &&
                   (busAddr <  ADDR_W'(DEST_BASE) + ADDR_W'(BLOCK_LEN))));

  assert_page_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st.finish && !st.loadPage) |=> (regRdData == '0));

endmodule

// File: rtl/oam_copy_top.sv
module oam_copy_top
  import oam_copy_pkg::*;
#(
  parameter int          ADDR_W         = 16,
  parameter int          DATA_W         = 8,
  parameter int          BLOCK_LEN      = 160,
  parameter int          STARTUP_CYCLES = 4,
  parameter int          SLOT_CYCLES    = 4,
  parameter logic [15:0] DEST_BASE      = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRdEn,
  input  logic [DATA_W-1:0] busRdData,
  output logic              busWrEn,
  output logic [DATA_W-1:0] busWrData,
  output logic              busy,
  output logic              done
);

  copyStrobes_t st;
  logic         lastIdx;

  oam_copy_ctrl #(
    .STARTUP_CYCLES(STARTUP_CYCLES),
    .SLOT_CYCLES   (SLOT_CYCLES)
  ) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .regWrEn(regWrEn),
    .lastIdx(lastIdx),
    .st     (st),
    .busy   (busy),
    .done   (done)
  );

  oam_copy_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BLOCK_LEN(BLOCK_LEN),
    .DEST_BASE(DEST_BASE)
  ) dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .regWrData(regWrData),
    .busRdData(busRdData),
    .regRdData(regRdData),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .lastIdx  (lastIdx)
  );

  assign busRdEn = st.rdSlot;
  assign busWrEn = st.wrSlot;

endmodule

// File: tb/oam_copy_top_tb_top.sv
`timescale 1ns/1ps
module oam_copy_top_tb_top;

  localparam int LEN      = 160;
  localparam int DONE_K   = 4 + 4 * LEN;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic [15:0] busAddr;
  logic        busRdEn;
  logic [7:0]  busRdData = 8'h00;
  logic        busWrEn;
  logic [7:0]  busWrData;
  logic        busy;
  logic        done;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  oam_copy_top dut_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .busAddr(busAddr), .busRdEn(busRdEn),
    .busRdData(busRdData), .busWrEn(busWrEn), .busWrData(busWrData),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5C;
  endfunction

  always @(posedge clk) busRdData <= busRdEn ? memByte(busAddr) : 8'h00;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic pageWrite(input logic [7:0] page);
    regWrEn   = 1'b1;
    regWrData = page;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  // Called at the negedge of cycle k=0; checks cycles 0..stopAt-1.
  task automatic trackCopy(input logic [7:0] page, input int stopAt);
    int nRd;
    int nWr;
    nRd = 0;
    nWr = 0;
    for (int k = 0; k < stopAt; k++) begin
      bit expRd, expWr;
      int i;
      expRd = (k >= 4) && ((k - 4) % 4 == 0) && ((k - 4) / 4 < LEN);
      expWr = (k >= 6) && ((k - 6) % 4 == 0) && ((k - 6) / 4 < LEN);
      if (k < 4) chk(!busRdEn && !busWrEn, "R3", {busRdEn, busWrEn}, 0);
      chk(busRdEn == expRd, "R4", busRdEn, expRd);
      chk(busWrEn == expWr, "R6", busWrEn, expWr);
      if (expRd) begin
        i = (k - 4) / 4;
        chk(busAddr == {page, 8'h00} + 16'(i), "R4", busAddr, {page, 8'h00} + 16'(i));
        nRd++;
      end
      if (expWr) begin
        i = (k - 6) / 4;
        chk(busAddr == 16'hFE00 + 16'(i), "R5", busAddr, 16'hFE00 + 16'(i));
        chk(busWrData == memByte({page, 8'h00} + 16'(i)), "R5", busWrData,
            memByte({page, 8'h00} + 16'(i)));
        nWr++;
      end
      if (k < DONE_K) begin
        chk(busy == 1'b1, "R2", busy, 1);
        chk(regRdData == page, "R2", regRdData, page);
        chk(done == 1'b0, "R7", done, 0);
      end else begin
        chk(done == (k == DONE_K), "R7", done, k == DONE_K);
        chk(busy == 1'b0, "R7", busy, 0);
        chk(regRdData == 8'h00, "R7", regRdData, 0);
      end
      @(negedge clk);
    end
    if (stopAt > DONE_K) begin
      chk(nRd == LEN, "R6", nRd, LEN);
      chk(nWr == LEN, "R6", nWr, LEN);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !busRdEn && !busWrEn, "R1",
        {busy, done, busRdEn, busWrEn}, 0);
    chk(regRdData == 8'h00, "R1", regRdData, 0);

    // Full copies over a spread of pages.
    for (int p = 0; p < 256; p += 51) begin
      pageWrite(8'(p));
      trackCopy(8'(p), DONE_K + 4);
    end
    pageWrite(8'hAB);
    trackCopy(8'hAB, DONE_K + 4);

    // R8: restart at every startup cycle and slot phase, then a mid-copy point.
    for (int cut = 0; cut < 9; cut++) begin
      pageWrite(8'h11);
      trackCopy(8'h11, cut);
      pageWrite(8'hC3);
      trackCopy(8'hC3, DONE_K + 2);
    end
    pageWrite(8'h40);
    trackCopy(8'h40, 301);
    pageWrite(8'h7E);
    trackCopy(8'h7E, DONE_K + 3); // R8 new page owns the whole copy

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule